// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. A sixteen-state controller follows the mode-select line on each rising edge of the test clock. The serial input is shifted into one of four chains: a 3-bit instruction chain, a 1-bit bypass chain, a 32-bit identification chain or an 85-bit boundary chain. The boundary chain takes a parallel snapshot of the I/O ring. The serial output changes on the falling edge of the test clock. It carries an enable that is high only while a chain is shifting. Outside those states the pad is meant to float.

The current instruction picks the data chain. It also sets a registered flag that tells the memory to put its data output drivers into high impedance. The opcode map is specific to this device. External test is 000. A second sampling opcode, 010, snapshots the ring and also floats the data outputs. The three unassigned opcodes act like bypass, so the chain length always stays defined. The memory array and the pad cells are outside this block.

Top module: `scan_tap_port`

## Requirements
- R1: A synchronous active-high `rst`, sampled on a rising `tck`, puts the controller in Test-Logic-Reset. In that state the current instruction becomes 001 and `out_hiz` becomes 0. `tdo_oe` is 0 after the next falling edge.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, with the same effects as R1.
- R3: In Capture-IR the instruction chain loads 001. In Shift-IR it shifts toward bit 0, with `tdi` entering at bit 2 and bit 0 appearing on `tdo`.
- R4: A shifted opcode becomes the current instruction, and changes `out_hiz`, only on the rising edge that leaves Update-IR. Until then `out_hiz` keeps its old value.
- R5: Opcode 001 selects the 32-bit identification chain. Capture-DR loads 0x0BA25069 into it: bits 31:29 = 000, 28:24 = 01011, 23:18 = 101000, 17:12 = 100101, 11:1 = 00000110100, bit 0 = 1.
- R6: Opcode 111, and the unassigned opcodes 011, 101 and 110, select a 1-bit bypass chain that captures 0.
- R7: Opcodes 000, 010 and 100 select the 85-bit boundary chain, which captures `ring_in` in Capture-DR. `ring_in[0]` is shifted out first.
- R8: `out_hiz` is 1 after opcode 000 or 010 is applied. It is 0 after 001, 100, 111 or any unassigned opcode.
- R9: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR. Otherwise `tdo` is driven 0 with `tdo_oe` low.
- R10: In Shift-DR the selected chain shifts toward bit 0, with `tdi` entering at the top bit. A bit entered on shift k therefore appears on `tdo` during shift k + length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, acts as test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| ring_in | input | BSR_LEN | Parallel snapshot of the I/O ring |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Drive enable for the serial output pad |
| out_hiz | output | 1 | Forces the memory data outputs to high impedance |

## Verification
Inputs are driven just after a falling edge. The serial output is read just before the next rising edge, which is the half-cycle after the falling edge that updated it. Each read therefore pairs with the bit shifted in on that same rising edge. A captured chain shows its bit 0 during the first Shift-DR cycle. A bit fed in on shift k is due back exactly `length` shifts later, so one 120-bit scan per opcode measures both the captured value and the chain length. `out_hiz` is read one full cycle after the rising edge that leaves Update-IR. It is also read while the controller is still in Exit1-IR, to show that it has not moved yet.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {CH_BYP, CH_ID, CH_BSR} chain_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic chain_t op_chain(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: op_chain = CH_BSR;
      OP_IDCODE:                        op_chain = CH_ID;
      default:                          op_chain = CH_BYP;
    endcase
  endfunction

  function automatic logic op_hiz(input logic [IR_W-1:0] op);
    op_hiz = (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SHF_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_cur,
  output logic            hiz
);

  always_ff @(posedge clk) begin
    if (rst || state == S_TLR) begin
      ir_sh  <= IR_CAPTURE;
      ir_cur <= OP_IDCODE;
      hiz    <= 1'b0;
    end else begin
      case (state)
        S_CAP_IR: ir_sh <= IR_CAPTURE;
        S_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        S_UPD_IR: begin
          ir_cur <= ir_sh;
          hiz    <= op_hiz(ir_sh);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 85,
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  tap_state_t         state,
  input  chain_t             sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ring_in,
  output logic               dr_lsb
);

  logic               byp;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp   <= 1'b0;
      id_sh <= '0;
      bsr   <= '0;
    end else if (state == S_CAP_DR) begin
      case (sel)
        CH_ID:   id_sh <= ID_VALUE;
        CH_BSR:  bsr   <= ring_in;
        default: byp   <= 1'b0;
      endcase
    end else if (state == S_SHF_DR) begin
      case (sel)
        CH_ID:   id_sh <= {tdi, id_sh[ID_W-1:1]};
        CH_BSR:  bsr   <= {tdi, bsr[BSR_LEN-1:1]};
        default: byp   <= tdi;
      endcase
    end
  end

  always_comb begin
    case (sel)
      CH_ID:   dr_lsb = id_sh[0];
      CH_BSR:  dr_lsb = bsr[0];
      default: dr_lsb = byp;
    endcase
  end

endmodule

// File: rtl/scan_tap_port.sv
`timescale 1ns/1ps
module scan_tap_port
  import scan_tap_pkg::*;
#(
  parameter int         BSR_LEN  = 85,
  parameter logic [2:0] ID_REV   = 3'b000,
  parameter logic [4:0] ID_DEPTH = 5'b01011,
  parameter logic [5:0] ID_ARCH  = 6'b101000,
  parameter logic [5:0] ID_DEV   = 6'b100101,
  parameter logic [10:0] ID_MFR  = 11'b00000110100
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ring_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               out_hiz
);

  localparam int        ID_W     = 32;
  localparam logic [ID_W-1:0] ID_VALUE =
    {ID_REV, ID_DEPTH, ID_ARCH, ID_DEV, ID_MFR, 1'b1};

  tap_state_t      state;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_cur;
  logic            dr_lsb;
  chain_t          sel;

  scan_tap_fsm u_fsm (
    .clk   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .clk    (tck),
    .rst    (rst),
    .state  (state),
    .tdi    (tdi),
    .ir_sh  (ir_sh),
    .ir_cur (ir_cur),
    .hiz    (out_hiz)
  );

  assign sel = op_chain(ir_cur);

  scan_tap_dr #(
    .BSR_LEN  (BSR_LEN),
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .clk     (tck),
    .rst     (rst),
    .state   (state),
    .sel     (sel),
    .tdi     (tdi),
    .ring_in (ring_in),
    .dr_lsb  (dr_lsb)
  );

  // Serial output is retimed to the falling edge.
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (state)
        S_SHF_IR: begin tdo <= ir_sh[0]; tdo_oe <= 1'b1; end
        S_SHF_DR: begin tdo <= dr_lsb;   tdo_oe <= 1'b1; end
        default:  begin tdo <= 1'b0;     tdo_oe <= 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/scan_tap_port_chk.sv
`timescale 1ns/1ps
module scan_tap_port_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_sh,
  input logic            out_hiz,
  input logic            tdo_oe
);

  logic [2:0] tms_run;

  always_ff @(posedge tck) begin
    if (rst)           tms_run <= 3'd0;
    else if (!tms)     tms_run <= 3'd0;
    else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
  end

  // R2: the fifth consecutive high TMS edge lands in Test-Logic-Reset
  p_five_high_tlr_r2: assert property (@(posedge tck) disable iff (rst)
    (tms && tms_run >= 3'd4) |=> (state == S_TLR));

  // R1: Test-Logic-Reset clears the high-Z flag
  p_tlr_clear_r1: assert property (@(posedge tck) disable iff (rst)
    (state == S_TLR) |=> !out_hiz);

  // R3: Capture-IR loads the fixed pattern
  p_ir_capture_r3: assert property (@(posedge tck) disable iff (rst)
    (state == S_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  // R4: the high-Z flag moves only when leaving Update-IR or in reset
  p_hiz_hold_r4: assert property (@(posedge tck) disable iff (rst)
    (state != S_UPD_IR && state != S_TLR) |=> $stable(out_hiz));

  // R9: output enable only in shift states
  p_oe_shift_r9: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == S_SHF_DR || state == S_SHF_IR));

endmodule

bind scan_tap_port scan_tap_port_chk u_chk (
  .tck     (tck),
  .rst     (rst),
  .tms     (tms),
  .state   (state),
  .ir_sh   (ir_sh),
  .out_hiz (out_hiz),
  .tdo_oe  (tdo_oe)
);

// File: tb/scan_tap_port_tb.sv
`timescale 1ns/1ps
module scan_tap_port_tb;

  localparam int BSR_LEN = 85;
  localparam int SCAN_N  = 120;
  localparam logic [31:0] ID_EXP =
    {3'b000, 5'b01011, 6'b101000, 6'b100101, 11'b00000110100, 1'b1};

  logic               tck = 1'b0;
  logic               rst = 1'b1;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] ring_in = '0;
  logic               tdo, tdo_oe, out_hiz;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  scan_tap_port u_dut (
    .tck     (tck),
    .rst     (rst),
    .tms     (tms),
    .tdi     (tdi),
    .ring_in (ring_in),
    .tdo     (tdo),
    .tdo_oe  (tdo_oe),
    .out_hiz (out_hiz)
  );

  always #2 tck = ~tck;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, read outputs before the rising edge.
  task automatic step(input logic m, input logic d,
                      output logic o, output logic oe);
    tms = m; tdi = d;
    o = tdo; oe = tdo_oe;
    @(posedge tck);
    @(negedge tck); #1;
  endtask

  // From Run-Test/Idle up to Exit1-IR, shifting op in.
  task automatic ir_shift(input logic [2:0] op, output logic [2:0] got,
                          output bit oe_ok);
    logic o, oe;
    oe_ok = 1;
    step(1, 0, o, oe); step(1, 0, o, oe);
    step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], o, oe);
      got[i] = o;
      if (!oe) oe_ok = 0;
    end
  endtask

  task automatic ir_finish();
    logic o, oe;
    step(1, 0, o, oe);
    step(0, 0, o, oe);
  endtask

  task automatic load_op(input logic [2:0] op);
    logic [2:0] got;
    bit oe_ok;
    ir_shift(op, got, oe_ok);
    chk(got == 3'b001, "R3 IR capture pattern", 128'(got), 128'(3'b001));
    chk(oe_ok, "R9 tdo_oe during Shift-IR", 128'(oe_ok), 128'd1);
    ir_finish();
  endtask

  task automatic dr_scan(input int n, input logic [127:0] din,
                         output logic [127:0] dout, output bit oe_ok);
    logic o, oe;
    dout = '0; oe_ok = 1;
    step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (!oe) oe_ok = 0;
    end
    step(1, 0, o, oe); step(0, 0, o, oe);
  endtask

  function automatic logic [127:0] expect_scan(input int len,
      input logic [127:0] cap, input logic [127:0] pat);
    logic [127:0] e = '0;
    for (int i = 0; i < SCAN_N; i++)
      e[i] = (i < len) ? cap[i] : pat[i - len];
    return e;
  endfunction

  function automatic int op_len(input logic [2:0] op);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return BSR_LEN;
    if (op == 3'b001) return 32;
    return 1;
  endfunction

  task automatic check_op(input logic [2:0] op, input logic [127:0] pat);
    logic [127:0] got, exp, cap;
    bit oe_ok;
    int len;
    load_op(op);
    chk(out_hiz == (op == 3'b000 || op == 3'b010), "R8 out_hiz per opcode",
        128'(out_hiz), 128'(op == 3'b000 || op == 3'b010));
    len = op_len(op);
    cap = (len == BSR_LEN) ? 128'(ring_in) : (len == 32) ? 128'(ID_EXP) : '0;
    dr_scan(SCAN_N, pat, got, oe_ok);
    exp = expect_scan(len, cap, pat);
    chk(got == exp, (len == BSR_LEN) ? "R7 R10 boundary chain" :
                    (len == 32) ? "R5 R10 id chain" : "R6 R10 bypass chain",
        got, exp);
    chk(oe_ok && !tdo_oe && !tdo, "R9 tdo_oe only in Shift-DR",
        128'({oe_ok, tdo_oe, tdo}), 128'(3'b100));
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat0, pat1, got;
    logic [2:0] gir;
    bit oe_ok;
    logic o, oe;
    pat0 = 128'h3C96_A50F_7E21_D4B8_96C3_5A0E_F187_2B4D;
    pat1 = 128'hE1D2_4B87_09F3_6CA5_1B7E_D024_8F6A_93C5;
    ring_in = {64'hA5C3_1E96_0F7B_D248, 21'h1B5A3};
    repeat (3) @(negedge tck);
    #1;
    chk(!out_hiz && !tdo_oe, "R1 reset outputs", 128'({out_hiz, tdo_oe}), 128'd0);
    rst = 0;
    step(0, 0, o, oe);
    chk(!tdo_oe && !tdo, "R9 idle tdo", 128'({tdo_oe, tdo}), 128'd0);

    // R1: IDCODE is current after reset
    dr_scan(SCAN_N, pat0, got, oe_ok);
    chk(got == expect_scan(32, 128'(ID_EXP), pat0), "R1 R5 idcode after reset",
        got, expect_scan(32, 128'(ID_EXP), pat0));
    chk(ID_EXP == 32'h0BA25069, "R5 id value", 128'(ID_EXP), 128'h0BA25069);

    // Sweep all opcodes with two patterns
    for (int k = 0; k < 8; k++) check_op(3'(k), pat0);
    ring_in = ~ring_in;
    for (int k = 7; k >= 0; k--) check_op(3'(k), pat1);

    // R4: hiz unchanged until Update-IR
    load_op(3'b000);
    chk(out_hiz, "R4 hiz set by 000", 128'(out_hiz), 128'd1);
    ir_shift(3'b100, gir, oe_ok);
    chk(out_hiz, "R4 hiz held in Exit1-IR", 128'(out_hiz), 128'd1);
    ir_finish();
    chk(!out_hiz, "R4 hiz cleared after update", 128'(out_hiz), 128'd0);

    // R2: five TMS-high cycles from Run-Test/Idle
    load_op(3'b010);
    chk(out_hiz, "R2 precondition hiz", 128'(out_hiz), 128'd1);
    for (int i = 0; i < 5; i++) step(1, 0, o, oe);
    chk(!out_hiz, "R2 hiz cleared by TMS reset", 128'(out_hiz), 128'd0);
    step(0, 0, o, oe);
    dr_scan(SCAN_N, pat1, got, oe_ok);
    chk(got == expect_scan(32, 128'(ID_EXP), pat1), "R2 idcode after TMS reset",
        got, expect_scan(32, 128'(ID_EXP), pat1));

    // R1: reset pulse in the middle of operation
    load_op(3'b000);
    rst = 1;
    step(0, 0, o, oe);
    rst = 0;
    chk(!out_hiz && !tdo_oe, "R1 reset mid-run", 128'({out_hiz, tdo_oe}), 128'd0);
    step(0, 0, o, oe);
    dr_scan(SCAN_N, pat0, got, oe_ok);
    chk(got == expect_scan(32, 128'(ID_EXP), pat0), "R1 idcode after reset pulse",
        got, expect_scan(32, 128'(ID_EXP), pat0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule